// File: doc/BRIEF.md
# CRT Display Timing Controller

This block produces the timing for a character-based raster display. It takes one step on every rising edge of its clock, which is the character clock. From a bank of sixteen 8-bit setup registers it derives five things: horizontal sync, vertical sync, a display-enable window, a memory refresh address for the character store, and the scan-row number within the current character row.

The vertical timing has two parts. First comes a whole number of character rows, each a programmable number of scan lines tall. Then comes a short adjust run of extra scan lines. After the adjust run, the next frame starts from a programmable start address. A host configures the block through two steps. It first latches a register index, then reads or writes that register through a data port.

Register offsets, which the host decodes:
- 0: horizontal total
- 1: characters displayed
- 2: horizontal sync position
- 3: sync width (low nibble)
- 4: vertical total
- 5: total adjust
- 6: rows displayed
- 7: vertical sync position
- 9: scan lines per row
- 12: start address, high byte
- 13: start address, low byte

Offsets 8, 10, 11, 14 and 15 are plain storage.

Top module: `crt_timing_ctrl`

## Requirements
- R1: The character counter advances once per clock and returns to 0 on the step where it would reach horizontal total + 1, so a line lasts (horizontal total + 1) clocks.
- R2: hsync rises on the step where the character counter reaches the sync position. It stays high for exactly N clocks, where N is bits [3:0] of the sync-width register; bits [7:4] are ignored. N = 0 gives no pulse.
- R3: Character visibility drops on the step where the counter reaches the displayed count and returns at the line wrap. On a visible row, disp_en is therefore high for that many clocks per line.
- R4: scan_row increments only at a line end. When it reaches the scan-lines-per-row value it returns to 0 and the row counter increments, so a row is that many scan lines tall. The register value must be at least 1.
- R5: Line visibility drops when the row counter reaches the rows-displayed value and returns when the adjust run ends. disp_en is the registered AND of character and line visibility.
- R6: vsync rises at the line end where the row counter reaches the vertical sync position. It stays high for exactly VS_LINES (16) scan lines, counted at line ends.
- R7: When the row counter reaches vertical total, the row and scan counters clear and an adjust run of total-adjust scan lines follows (the value must be at least 1). At the end of that run, refresh_addr loads {high, low} of the start address, truncated to MA_W bits. A frame is therefore (vertical total × lines per row + adjust) scan lines long.
- R8: The select port keeps only bits [3:0] of the written index. reg_rdata shows the selected register. status_rdata always reads 8'hFF.
- R9: At a line end on the last scan line of a row, refresh_addr continues one past its last value, and that value becomes the next row's base. At every other line end outside the adjust run, refresh_addr returns to the current row's base.
- R10: Within a line, refresh_addr increments by one on every clock, modulo 2^MA_W.
- R11: While rst is high the counters hold at zero and hsync, vsync, disp_en, refresh_addr and scan_row are 0. Register writes are accepted during reset and take effect from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset of counters and outputs, active high |
| sel_we | input | 1 | Latch a register index from sel_data |
| sel_data | input | 8 | Register index; only bits [3:0] are kept |
| reg_we | input | 1 | Write reg_wdata into the selected register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the selected register |
| status_rdata | output | 8 | Status byte, always 8'hFF |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Display enable |
| refresh_addr | output | MA_W (14) | Memory refresh address |
| scan_row | output | RA_W (5) | Scan line within the character row |

## Verification
On every cycle, the bound checker confirms four things: the character counter wraps to zero after each line end, hsync never starts with a zero width, scan_row and vsync change only at line ends, and refresh_addr steps by exactly one between line ends. The bench's scenarios are needed for behaviour that spans many cycles. These include the measured hsync and vsync pulse lengths, the line and frame periods, the width of the disp_en window, the start-address reload after the adjust run, and the host select masking and readback. A step-by-step model in the bench compares every output on every cycle.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  localparam int DW    = 8;
  localparam int SEL_W = 4;
  localparam int NREG  = 1 << SEL_W;

  // Register offsets decoded by the host side
  localparam int IX_HTOT  = 0;
  localparam int IX_HDISP = 1;
  localparam int IX_HSPOS = 2;
  localparam int IX_SWID  = 3;
  localparam int IX_VTOT  = 4;
  localparam int IX_VADJ  = 5;
  localparam int IX_VDISP = 6;
  localparam int IX_VSPOS = 7;
  localparam int IX_MAXSL = 9;
  localparam int IX_STHI  = 12;
  localparam int IX_STLO  = 13;

  typedef struct packed {
    logic [DW-1:0]   h_total;
    logic [DW-1:0]   h_disp;
    logic [DW-1:0]   hs_pos;
    logic [3:0]      hs_width;
    logic [DW-1:0]   v_total;
    logic [DW-1:0]   v_adj;
    logic [DW-1:0]   v_disp;
    logic [DW-1:0]   vs_pos;
    logic [DW-1:0]   max_scan;
    logic [2*DW-1:0] start;
  } timing_cfg_t;

  // Next character count, one bit wider so that total+1 never wraps
  function automatic logic [DW:0] char_advance(input logic [DW-1:0] cc);
    return {1'b0, cc} + {{DW{1'b0}}, 1'b1};
  endfunction

  // Line end when the advanced count reaches total + 1
  function automatic logic is_line_wrap(input logic [DW:0] nxt, input logic [DW-1:0] tot);
    return nxt == ({1'b0, tot} + {{DW{1'b0}}, 1'b1});
  endfunction

  function automatic logic [2*DW-1:0] join_start(input logic [DW-1:0] hi, input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic          clk,
  input  logic          sel_we,
  input  logic [7:0]    sel_data,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output timing_cfg_t   cfg
);

  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    regs [NREG];
  logic             unused_sel_hi;

  assign unused_sel_hi = &{1'b0, sel_data[7:SEL_W]};

  always_ff @(posedge clk) begin
    if (sel_we) sel_q <= sel_data[SEL_W-1:0];
  end

  // Setup registers carry no reset: they are written before timing starts
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (reg_we && (sel_q == SEL_W'(i))) regs[i] <= reg_wdata;
    end
  end

  assign reg_rdata = regs[sel_q];

  always_comb begin
    cfg.h_total  = regs[IX_HTOT];
    cfg.h_disp   = regs[IX_HDISP];
    cfg.hs_pos   = regs[IX_HSPOS];
    cfg.hs_width = regs[IX_SWID][3:0];
    cfg.v_total  = regs[IX_VTOT];
    cfg.v_adj    = regs[IX_VADJ];
    cfg.v_disp   = regs[IX_VDISP];
    cfg.vs_pos   = regs[IX_VSPOS];
    cfg.max_scan = regs[IX_MAXSL];
    cfg.start    = join_start(regs[IX_STHI], regs[IX_STLO]);
  end

endmodule

// File: rtl/crtc_horiz.sv
module crtc_horiz
  import crtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] h_total,
  input  logic [DW-1:0] h_disp,
  input  logic [DW-1:0] hs_pos,
  input  logic [3:0]    hs_width,
  output logic          line_end,
  output logic          hsync,
  output logic          char_vis_nxt,
  output logic [DW-1:0] col_cnt
);

  logic [DW:0]   cc_adv;
  logic          wrap_hit;
  logic [DW-1:0] cc_n;
  logic [3:0]    hs_cnt_q, hs_cnt_n;
  logic          hs_n;
  logic          cv_q;

  assign cc_adv   = char_advance(col_cnt);
  assign wrap_hit = is_line_wrap(cc_adv, h_total);
  assign line_end = !rst && wrap_hit;

  always_comb begin
    hs_cnt_n = hs_cnt_q;
    hs_n     = hsync;
    if (hs_cnt_q != 4'd0) begin
      hs_cnt_n = hs_cnt_q - 4'd1;
      if (hs_cnt_n == 4'd0) hs_n = 1'b0;
    end
    if (cc_adv == {1'b0, hs_pos}) begin
      hs_cnt_n = hs_width;
      hs_n     = (hs_width != 4'd0);
    end
  end

  always_comb begin
    char_vis_nxt = cv_q;
    cc_n         = cc_adv[DW-1:0];
    if (cc_adv == {1'b0, h_disp}) char_vis_nxt = 1'b0;
    if (wrap_hit) begin
      char_vis_nxt = 1'b1;
      cc_n         = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_cnt  <= '0;
      hs_cnt_q <= '0;
      hsync    <= 1'b0;
      cv_q     <= 1'b1;
    end else begin
      col_cnt  <= cc_n;
      hs_cnt_q <= hs_cnt_n;
      hsync    <= hs_n;
      cv_q     <= char_vis_nxt;
    end
  end

endmodule

// File: rtl/crtc_vert.sv
module crtc_vert
  import crtc_pkg::*;
#(
  parameter int MA_W     = 14,
  parameter int RA_W     = 5,
  parameter int VS_LINES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_end,
  input  logic [DW-1:0]   v_total,
  input  logic [DW-1:0]   v_adj,
  input  logic [DW-1:0]   v_disp,
  input  logic [DW-1:0]   vs_pos,
  input  logic [DW-1:0]   max_scan,
  input  logic [2*DW-1:0] start,
  output logic            vsync,
  output logic            line_vis_nxt,
  output logic            in_adjust,
  output logic [MA_W-1:0] refresh_addr,
  output logic [RA_W-1:0] scan_row
);

  localparam int VC_W = $clog2(VS_LINES + 1);

  logic [DW-1:0]   ra_q, ra_n;
  logic [DW-1:0]   lc_q, lc_n;
  logic            adj_n, lv_q, vs_n;
  logic [VC_W-1:0] vc_q, vc_n;
  logic [MA_W-1:0] base_q, base_n, ma_n, ma_inc;
  logic            unused_bits;

  assign unused_bits = &{1'b0, start[2*DW-1:MA_W], ra_q[DW-1:RA_W]};
  assign ma_inc      = refresh_addr + MA_W'(1);

  always_comb begin
    ra_n         = ra_q;
    lc_n         = lc_q;
    adj_n        = in_adjust;
    line_vis_nxt = lv_q;
    vs_n         = vsync;
    vc_n         = vc_q;
    base_n       = base_q;
    ma_n         = ma_inc;
    if (line_end) begin
      if (vc_q != '0) begin
        vc_n = vc_q - VC_W'(1);
        if (vc_n == '0) vs_n = 1'b0;
      end
      if (in_adjust) begin
        lc_n = lc_q + DW'(1);
        if (lc_n == v_adj) begin
          line_vis_nxt = 1'b1;
          lc_n         = '0;
          adj_n        = 1'b0;
          base_n       = start[MA_W-1:0];
          ma_n         = start[MA_W-1:0];
        end
      end else begin
        ra_n = ra_q + DW'(1);
        if (ra_n == max_scan) begin
          ra_n   = '0;
          base_n = ma_inc;
          lc_n   = lc_q + DW'(1);
          if (lc_n == v_disp) line_vis_nxt = 1'b0;
          if (lc_n == vs_pos) begin
            vs_n = 1'b1;
            vc_n = VC_W'(VS_LINES);
          end
          if (lc_n == v_total) begin
            adj_n = 1'b1;
            lc_n  = '0;
          end
        end else begin
          ma_n = base_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q         <= '0;
      lc_q         <= '0;
      in_adjust    <= 1'b0;
      lv_q         <= 1'b1;
      vsync        <= 1'b0;
      vc_q         <= '0;
      base_q       <= '0;
      refresh_addr <= '0;
    end else begin
      ra_q         <= ra_n;
      lc_q         <= lc_n;
      in_adjust    <= adj_n;
      lv_q         <= line_vis_nxt;
      vsync        <= vs_n;
      vc_q         <= vc_n;
      base_q       <= base_n;
      refresh_addr <= ma_n;
    end
  end

  assign scan_row = ra_q[RA_W-1:0];

endmodule

// File: rtl/crt_timing_ctrl.sv
module crt_timing_ctrl
  import crtc_pkg::*;
#(
  parameter int MA_W     = 14,
  parameter int RA_W     = 5,
  parameter int VS_LINES = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_we,
  input  logic [7:0]      sel_data,
  input  logic            reg_we,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  output logic [7:0]      status_rdata,
  output logic            hsync,
  output logic            vsync,
  output logic            disp_en,
  output logic [MA_W-1:0] refresh_addr,
  output logic [RA_W-1:0] scan_row
);

  timing_cfg_t   cfg;
  logic          line_end;
  logic          char_vis_nxt;
  logic          line_vis_nxt;
  logic          in_adjust;
  logic [DW-1:0] col_cnt;
  logic [3:0]    cfg_hs_width;

  assign status_rdata = 8'hFF;
  assign cfg_hs_width = cfg.hs_width;

  crtc_regfile u_regs (
    .clk       (clk),
    .sel_we    (sel_we),
    .sel_data  (sel_data),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg       (cfg)
  );

  crtc_horiz u_horiz (
    .clk          (clk),
    .rst          (rst),
    .h_total      (cfg.h_total),
    .h_disp       (cfg.h_disp),
    .hs_pos       (cfg.hs_pos),
    .hs_width     (cfg.hs_width),
    .line_end     (line_end),
    .hsync        (hsync),
    .char_vis_nxt (char_vis_nxt),
    .col_cnt      (col_cnt)
  );

  crtc_vert #(
    .MA_W     (MA_W),
    .RA_W     (RA_W),
    .VS_LINES (VS_LINES)
  ) u_vert (
    .clk          (clk),
    .rst          (rst),
    .line_end     (line_end),
    .v_total      (cfg.v_total),
    .v_adj        (cfg.v_adj),
    .v_disp       (cfg.v_disp),
    .vs_pos       (cfg.vs_pos),
    .max_scan     (cfg.max_scan),
    .start        (cfg.start),
    .vsync        (vsync),
    .line_vis_nxt (line_vis_nxt),
    .in_adjust    (in_adjust),
    .refresh_addr (refresh_addr),
    .scan_row     (scan_row)
  );

  always_ff @(posedge clk) begin
    if (rst) disp_en <= 1'b0;
    else     disp_en <= char_vis_nxt && line_vis_nxt;
  end

endmodule

// File: rtl/crtc_checker.sv
module crtc_checker #(
  parameter int MA_W = 14,
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            line_end,
  input logic [7:0]      col_cnt,
  input logic [3:0]      cfg_hs_width,
  input logic            hsync,
  input logic            vsync,
  input logic            disp_en,
  input logic [MA_W-1:0] refresh_addr,
  input logic [RA_W-1:0] scan_row
);

  // R1
  line_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    line_end |=> (col_cnt == 8'd0));

  // R2
  hsync_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> ($past(cfg_hs_width) != 4'd0));

  // R4
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(line_end)) |-> $stable(scan_row));

  // R6
  vsync_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && (vsync != $past(vsync))) |-> $past(line_end));

  // R10
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(line_end)) |-> (refresh_addr == MA_W'($past(refresh_addr) + MA_W'(1))));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!hsync && !vsync && !disp_en && refresh_addr == '0 && scan_row == '0) || !$past(rst));

endmodule

bind crt_timing_ctrl crtc_checker #(.MA_W(MA_W), .RA_W(RA_W)) u_crtc_checker (
  .clk          (clk),
  .rst          (rst),
  .line_end     (line_end),
  .col_cnt      (col_cnt),
  .cfg_hs_width (cfg_hs_width),
  .hsync        (hsync),
  .vsync        (vsync),
  .disp_en      (disp_en),
  .refresh_addr (refresh_addr),
  .scan_row     (scan_row)
);

// File: tb/crt_timing_ctrl_bench.sv
`timescale 1ns/1ps
module crt_timing_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_we = 1'b0;
  logic [7:0]  sel_data = 8'd0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata, status_rdata;
  logic        hsync, vsync, disp_en;
  logic [13:0] refresh_addr;
  logic [4:0]  scan_row;

  int n_checks = 0;
  int n_errors = 0;
  bit cmp_on = 1'b0;
  int cfg_v [16];

  always #5 clk = ~clk;

  crt_timing_ctrl u_crt_timing_ctrl (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_data(sel_data),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status_rdata(status_rdata), .hsync(hsync), .vsync(vsync),
    .disp_en(disp_en), .refresh_addr(refresh_addr), .scan_row(scan_row)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- step model written from the requirements ----------------
  int sh [16];
  int m_sel, m_cc, m_hc, m_hs, m_cv, m_ra, m_lc, m_adj, m_lv, m_vs, m_vc;
  int m_base, m_ma, m_de, m_nx;

  task automatic model_line_end();
    if (m_vc > 0) begin m_vc--; if (m_vc == 0) m_vs = 0; end
    if (m_adj != 0) begin
      m_lc = (m_lc + 1) % 256;
      if (m_lc == sh[5]) begin
        m_lv = 1; m_lc = 0; m_adj = 0;
        m_base = (sh[12] * 256 + sh[13]) % 16384;
        m_ma = m_base;
      end else m_ma = (m_ma + 1) % 16384;
    end else begin
      m_ra = (m_ra + 1) % 256;
      if (m_ra == sh[9]) begin
        m_ra = 0;
        m_ma = (m_ma + 1) % 16384;
        m_base = m_ma;
        m_lc = (m_lc + 1) % 256;
        if (m_lc == sh[6]) m_lv = 0;
        if (m_lc == sh[7]) begin m_vs = 1; m_vc = 16; end
        if (m_lc == sh[4]) begin m_adj = 1; m_lc = 0; end
      end else m_ma = m_base;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cc = 0; m_hc = 0; m_hs = 0; m_cv = 1; m_ra = 0; m_lc = 0; m_adj = 0;
      m_lv = 1; m_vs = 0; m_vc = 0; m_base = 0; m_ma = 0; m_de = 0;
    end else begin
      m_nx = m_cc + 1;
      if (m_hc > 0) begin m_hc--; if (m_hc == 0) m_hs = 0; end
      if (m_nx == sh[2]) begin m_hc = sh[3] % 16; m_hs = (m_hc != 0) ? 1 : 0; end
      if (m_nx == sh[1]) m_cv = 0;
      if (m_nx == sh[0] + 1) begin
        m_cc = 0; m_cv = 1;
        model_line_end();
      end else begin
        m_cc = m_nx % 256;
        m_ma = (m_ma + 1) % 16384;
      end
      m_de = (m_cv != 0 && m_lv != 0) ? 1 : 0;
    end
    if (reg_we) sh[m_sel] = reg_wdata;
    if (sel_we) m_sel = sel_data % 16;
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 hsync vs model", hsync, m_hs);
      chk("R6 vsync vs model", vsync, m_vs);
      chk("R5 disp_en vs model", disp_en, m_de);
      chk("R9 refresh_addr vs model", refresh_addr, m_ma);
      chk("R4 scan_row vs model", scan_row, m_ra % 32);
    end
  end

  // ---------------- helpers ----------------
  task automatic write_reg(input int idx, input int val);
    @(negedge clk); sel_we = 1'b1; sel_data = 8'(idx);
    @(negedge clk); sel_we = 1'b0; reg_we = 1'b1; reg_wdata = 8'(val);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic restart_with_cfg();
    cmp_on = 1'b0;
    @(negedge clk); rst = 1'b1;
    for (int i = 0; i < 16; i++) write_reg(i, cfg_v[i]);
    @(negedge clk);
    // R11: outputs cleared while reset is held
    chk("R11 hsync in reset", hsync, 0);
    chk("R11 vsync in reset", vsync, 0);
    chk("R11 disp_en in reset", disp_en, 0);
    chk("R11 refresh_addr in reset", refresh_addr, 0);
    chk("R11 scan_row in reset", scan_row, 0);
    rst = 1'b0;
    cmp_on = 1'b1;
  endtask

  function automatic int pick(input int which);
    case (which)
      0: return int'(hsync);
      1: return int'(vsync);
      default: return int'(disp_en);
    endcase
  endfunction

  task automatic scan_runs(input int which, input int ncyc, output int run_len, output int period);
    int prev, t1, t2, tf, s;
    t1 = -1; t2 = -1; tf = -1;
    @(negedge clk);
    prev = pick(which);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      s = pick(which);
      if (s == 1 && prev == 0) begin
        if (t1 < 0) t1 = i; else if (t2 < 0) t2 = i;
      end
      if (s == 0 && prev == 1 && t1 >= 0 && tf < 0) tf = i;
      prev = s;
    end
    run_len = (t1 >= 0 && tf >= 0) ? tf - t1 : -1;
    period  = (t1 >= 0 && t2 >= 0) ? t2 - t1 : -1;
  endtask

  task automatic base_cfg();
    for (int i = 0; i < 16; i++) cfg_v[i] = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic test_horizontal();
    int rl, per;
    base_cfg();
    cfg_v[0] = 9; cfg_v[1] = 6; cfg_v[2] = 4; cfg_v[3] = 8'hF3;
    cfg_v[4] = 5; cfg_v[5] = 1; cfg_v[6] = 5; cfg_v[7] = 200; cfg_v[9] = 2;
    restart_with_cfg();
    scan_runs(0, 60, rl, per);
    chk("R2 hsync width from low nibble", rl, 3);
    chk("R1 line period", per, 10);
    scan_runs(2, 60, rl, per);
    chk("R3 disp_en window width", rl, 6);
    chk("R3 disp_en period", per, 10);
  endtask

  task automatic test_zero_width();
    int hi;
    base_cfg();
    cfg_v[0] = 7; cfg_v[1] = 4; cfg_v[2] = 5; cfg_v[3] = 8'h10;
    cfg_v[4] = 4; cfg_v[5] = 1; cfg_v[6] = 3; cfg_v[7] = 200; cfg_v[9] = 3;
    restart_with_cfg();
    hi = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (hsync) hi++;
    end
    chk("R2 zero width gives no hsync", hi, 0);
  endtask

  task automatic test_vertical();
    int rl, per, found, maxra, vis_adj;
    base_cfg();
    cfg_v[0] = 3; cfg_v[1] = 2; cfg_v[2] = 2; cfg_v[3] = 1;
    cfg_v[4] = 10; cfg_v[5] = 2; cfg_v[6] = 8; cfg_v[7] = 3; cfg_v[9] = 2;
    cfg_v[12] = 8'h12; cfg_v[13] = 8'h34;
    restart_with_cfg();
    scan_runs(1, 250, rl, per);
    chk("R6 vsync lasts 16 lines", rl, 64);
    chk("R7 frame period 22 lines", per, 88);
    found = 0; maxra = 0; vis_adj = 0;
    for (int i = 0; i < 180; i++) begin
      @(negedge clk);
      if (refresh_addr == 14'h1234 && scan_row == 5'd0) found = 1;
      if (int'(scan_row) > maxra) maxra = int'(scan_row);
    end
    chk("R7 start address reload", found, 1);
    chk("R4 scan row stays below lines-per-row", maxra, 1);
  endtask

  task automatic test_host();
    write_reg(8'h4F, 8'hA7);
    @(negedge clk); sel_we = 1'b1; sel_data = 8'h0F;
    @(negedge clk); sel_we = 1'b0;
    chk("R8 readback of selected register", reg_rdata, 8'hA7);
    @(negedge clk); sel_we = 1'b1; sel_data = 8'hE3;
    @(negedge clk); sel_we = 1'b0;
    chk("R8 high index bits ignored", reg_rdata, 8'h01);
    chk("R8 status reads all ones", status_rdata, 8'hFF);
  endtask

  task automatic test_live_write();
    // R1: a new horizontal total written while running sets the next line length
    int rl, per;
    write_reg(0, 5);
    scan_runs(0, 40, rl, per);
    chk("R1 line period after live write", per, 6);
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_horizontal();
    test_zero_width();
    test_vertical();
    test_host();
    test_live_write();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule